// File: doc/BRIEF.md
# SDRAM Precharge and Power-Down Manager

This block keeps track of which banks of an SDRAM have a row open and drives the command pins for three operations: closing rows, opening rows, and the power-down sequence. A host asks it to close one bank or every bank, to open a row in a bank, to enter power-down, or to wake up. It also answers each access request with a grant or a reject, based on whether the target bank has a row open. It drives chip select, row strobe, column strobe, write enable, the A10 line, the bank address and the clock-enable pin. It reports the open/idle state of each bank and the kind of power-down in progress.

A row close applies to every bank when A10 is high. When A10 is low it applies only to the bank that the bank address selects. A closed bank cannot be reopened until a row-precharge delay has elapsed. Power-down is entered by dropping clock enable while a no-operation command is on the pins. It is classed as idle-bank or open-row power-down from the live bank state at entry. A cycle counter forces a wake-up, with a margin, before the refresh interval runs out. On exit, clock enable rises and no-operation is held for a setup window before any new command.

Top module: `sdram_pwr_mgr`

## Requirements
- R1: When a close-all request is taken, the next cycle shows {csN,rasN,casN,weN}=4'b0010 with a10=1 and ba=0. Every bit of bankOpen is 0 in that same cycle.
- R2: When a single-bank close is taken (preAll=0), the next cycle shows 4'b0010 with a10=0 and ba=preBank. Only that bank's bankOpen bit clears; the other bits keep their values.
- R3: An open request is issued one cycle after it is sampled, as 4'b0011 with ba=actBank and a10=actA10, and it sets bankOpen[actBank]. It is held off until TRP cycles after the cycle in which that bank's close appeared on the pins. It is never issued to a bank whose row is already open.
- R4: One cycle after accReq, accGrant=1 if the bank is open and the block is awake. Otherwise accReject=1. The two are never high together.
- R5: With pdReq high, accBusy low and no close or open request, the next cycle shows cke=0 with 4'b0111 (no-operation) and pdActive=1. While accBusy is high, cke stays 1.
- R6: pdMode is 0 if every bank was idle at power-down entry and 1 if any row was open. It holds that value while pdActive is high.
- R7: While cke is low, and during the exit window, the pins show only no-operation, and close or open requests do not change bankOpen.
- R8: wakeReq during power-down raises cke in the next cycle. No-operation is held so that the first non-no-operation command appears exactly TCKS+1 cycles after the first cycle with cke high.
- R9: cke stays low for at most FORCE_AT = PD_LIMIT-PD_MARGIN consecutive cycles. With no wake request, cke rises exactly at that count.
- R10: After reset, cke=1, the pins show no-operation, bankOpen=0, and pdActive, pdMode, accGrant and accReject are 0.
- R11: When a close request and an open request arrive in the same cycle, the close is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| preReq | input | 1 | Request to close rows |
| preAll | input | 1 | Close every bank when high |
| preBank | input | 2 | Bank to close when preAll is low |
| actReq | input | 1 | Request to open a row (level, held until issued) |
| actBank | input | 2 | Bank to open |
| actA10 | input | 1 | Row-address bit placed on A10 with the open command |
| accReq | input | 1 | Access request to be checked |
| accBank | input | 2 | Bank of the access request |
| accBusy | input | 1 | An access is in progress; blocks power-down entry |
| pdReq | input | 1 | Request to enter power-down |
| wakeReq | input | 1 | Request to leave power-down |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| a10 | output | 1 | A10 line |
| ba | output | 2 | Bank address |
| cke | output | 1 | Clock enable |
| bankOpen | output | 4 | Per-bank row-open flags |
| pdActive | output | 1 | High while cke is held low |
| pdMode | output | 1 | 1 = open-row power-down, 0 = idle-bank power-down |
| accGrant | output | 1 | Access accepted |
| accReject | output | 1 | Access refused |

## Verification
All sixteen patterns of open banks are built up. Each one is followed by a close-all, an access sweep over every bank and a power-down entry. This separates the idle-bank and open-row power-down classes and checks per-bank grant and reject against each pattern. A close of each single bank against a fully open set shows whether only the selected bank is cleared. A close followed by a held open request measures the row-precharge delay exactly. A timed wake with a held close request, and an unwoken power-down, measure the exit window and the forced-exit count to the cycle. Requests pulsed during power-down show that the bank state and the pins stay untouched.

// File: rtl/sdpm_pkg.sv
package sdpm_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_PD    = 2'd1,
    ST_EXIT  = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic doPre;
    logic doAct;
    logic doEnter;
    logic doWake;
    logic doResume;
  } strobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_ACT = 4'b0011;

endpackage

// File: rtl/sdpm_ctrl.sv
module sdpm_ctrl
  import sdpm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      preReq,
  input  logic      actReq,
  input  logic      pdReq,
  input  logic      wakeReq,
  input  logic      accBusy,
  input  logic      actOk,
  input  logic      forceExit,
  input  logic      exitDone,
  output strobe_t   stb,
  output pwrState_t state,
  output logic      pdActive
);

  pwrState_t stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_AWAKE: begin
        if (preReq) begin
          stb.doPre = 1'b1;                 // close has priority
        end else if (actReq && actOk) begin
          stb.doAct = 1'b1;
        end else if (pdReq && !accBusy && !actReq) begin
          stb.doEnter = 1'b1;
          stateNext   = ST_PD;
        end
      end
      ST_PD: begin
        if (wakeReq || forceExit) begin
          stb.doWake = 1'b1;
          stateNext  = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (exitDone) begin
          stb.doResume = 1'b1;
          stateNext    = ST_AWAKE;
        end
      end
      default: stateNext = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_AWAKE;
    else       state <= stateNext;
  end

  assign pdActive = (state == ST_PD);

  // Leaving power-down always passes through the exit window.
  AST_PD_VIA_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PD) |=> (state != ST_AWAKE)); // R8

  // No command request is honoured outside the awake state.
  AST_NO_CMD_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_AWAKE) |-> !(stb.doPre || stb.doAct)); // R7

endmodule

// File: rtl/sdpm_datapath.sv
module sdpm_datapath
  import sdpm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP       = 3,
  parameter int TCKS      = 2,
  parameter int FORCE_AT  = 100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  pwrState_t                    state,
  input  logic                         preAll,
  input  logic [$clog2(NUM_BANKS)-1:0] preBank,
  input  logic [$clog2(NUM_BANKS)-1:0] actBank,
  input  logic                         actA10,
  input  logic                         accReq,
  input  logic [$clog2(NUM_BANKS)-1:0] accBank,
  output logic [3:0]                   cmdPins,
  output logic                         a10,
  output logic [$clog2(NUM_BANKS)-1:0] ba,
  output logic                         cke,
  output logic [NUM_BANKS-1:0]         bankOpen,
  output logic                         pdMode,
  output logic                         accGrant,
  output logic                         accReject,
  output logic                         actOk,
  output logic                         forceExit,
  output logic                         exitDone
);

  localparam int BA_W = $clog2(NUM_BANKS);
  localparam int RP_W = $clog2(TRP + 1);
  localparam int PD_W = $clog2(FORCE_AT + 1);
  localparam int EX_W = $clog2(TCKS + 1);
  localparam logic [RP_W-1:0] RP_LOAD  = RP_W'(TRP - 1);
  localparam logic [EX_W-1:0] EX_LOAD  = EX_W'(TCKS - 1);
  localparam logic [PD_W-1:0] PD_FINAL = PD_W'(FORCE_AT - 1);

  logic [NUM_BANKS-1:0] rpZero;

  // Per-bank row state and precharge-delay timer
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic            preHit;
    logic            actHit;
    logic            openQ;
    logic [RP_W-1:0] rpCnt;

    assign preHit = stb.doPre && (preAll || (preBank == BA_W'(b)));
    assign actHit = stb.doAct && (actBank == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rpCnt <= '0;
      end else if (preHit) begin
        openQ <= 1'b0;
        rpCnt <= RP_LOAD;
      end else begin
        if (actHit) openQ <= 1'b1;
        if (rpCnt != '0) rpCnt <= rpCnt - RP_W'(1);
      end
    end

    assign bankOpen[b] = openQ;
    assign rpZero[b]   = (rpCnt == '0);
  end

  assign actOk = !bankOpen[actBank] && rpZero[actBank];

  // Power-down residency counter
  logic [PD_W-1:0] pdCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                 pdCnt <= '0;
    else if (stb.doEnter)      pdCnt <= '0;
    else if (state == ST_PD)   pdCnt <= pdCnt + PD_W'(1);
  end

  assign forceExit = (state == ST_PD) && (pdCnt == PD_FINAL);

  // Exit setup window counter
  logic [EX_W-1:0] exitCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                      exitCnt <= '0;
    else if (stb.doWake)                            exitCnt <= EX_LOAD;
    else if ((state == ST_EXIT) && (exitCnt != '0)) exitCnt <= exitCnt - EX_W'(1);
  end

  assign exitDone = (state == ST_EXIT) && (exitCnt == '0);

  // Clock enable and power-down class
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cke    <= 1'b1;
      pdMode <= 1'b0;
    end else begin
      if (stb.doEnter) begin
        cke    <= 1'b0;
        pdMode <= |bankOpen;
      end else if (stb.doWake) begin
        cke <= 1'b1;
      end
      if (stb.doResume) pdMode <= 1'b0;
    end
  end

  // Command pin register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPins <= CMD_NOP;
      a10     <= 1'b0;
      ba      <= '0;
    end else if (stb.doPre) begin
      cmdPins <= CMD_PRE;
      a10     <= preAll;
      ba      <= preAll ? '0 : preBank;
    end else if (stb.doAct) begin
      cmdPins <= CMD_ACT;
      a10     <= actA10;
      ba      <= actBank;
    end else begin
      cmdPins <= CMD_NOP;
      a10     <= 1'b0;
      ba      <= '0;
    end
  end

  // Access check
  logic accHit;
  assign accHit = (state == ST_AWAKE) && bankOpen[accBank];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accGrant  <= 1'b0;
      accReject <= 1'b0;
    end else begin
      accGrant  <= accReq && accHit;
      accReject <= accReq && !accHit;
    end
  end

  AST_PRE_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdPins == CMD_PRE) && a10) |-> (bankOpen == '0)); // R1

  AST_ACT_MARKS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPins == CMD_ACT) |-> bankOpen[ba]); // R3

  AST_ACT_AFTER_TRP: assert property (@(posedge clk) disable iff (!rstN)
    stb.doAct |-> rpZero[actBank]); // R3

  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(accGrant && accReject)); // R4

  AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (cmdPins == CMD_NOP)); // R7

  AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (cmdPins == CMD_NOP)); // R8

  AST_PD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (pdCnt <= PD_FINAL)); // R9

endmodule

// File: rtl/sdram_pwr_mgr.sv
module sdram_pwr_mgr
  import sdpm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP       = 3,
  parameter int TCKS      = 2,
  parameter int PD_LIMIT  = 6400000,
  parameter int PD_MARGIN = 100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         preReq,
  input  logic                         preAll,
  input  logic [$clog2(NUM_BANKS)-1:0] preBank,
  input  logic                         actReq,
  input  logic [$clog2(NUM_BANKS)-1:0] actBank,
  input  logic                         actA10,
  input  logic                         accReq,
  input  logic [$clog2(NUM_BANKS)-1:0] accBank,
  input  logic                         accBusy,
  input  logic                         pdReq,
  input  logic                         wakeReq,
  output logic                         csN,
  output logic                         rasN,
  output logic                         casN,
  output logic                         weN,
  output logic                         a10,
  output logic [$clog2(NUM_BANKS)-1:0] ba,
  output logic                         cke,
  output logic [NUM_BANKS-1:0]         bankOpen,
  output logic                         pdActive,
  output logic                         pdMode,
  output logic                         accGrant,
  output logic                         accReject
);

  localparam int FORCE_AT = PD_LIMIT - PD_MARGIN;

  strobe_t    stb;
  pwrState_t  state;
  logic       actOk;
  logic       forceExit;
  logic       exitDone;
  logic [3:0] cmdPins;

  sdpm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .preReq    (preReq),
    .actReq    (actReq),
    .pdReq     (pdReq),
    .wakeReq   (wakeReq),
    .accBusy   (accBusy),
    .actOk     (actOk),
    .forceExit (forceExit),
    .exitDone  (exitDone),
    .stb       (stb),
    .state     (state),
    .pdActive  (pdActive)
  );

  sdpm_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .TRP       (TRP),
    .TCKS      (TCKS),
    .FORCE_AT  (FORCE_AT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .state     (state),
    .preAll    (preAll),
    .preBank   (preBank),
    .actBank   (actBank),
    .actA10    (actA10),
    .accReq    (accReq),
    .accBank   (accBank),
    .cmdPins   (cmdPins),
    .a10       (a10),
    .ba        (ba),
    .cke       (cke),
    .bankOpen  (bankOpen),
    .pdMode    (pdMode),
    .accGrant  (accGrant),
    .accReject (accReject),
    .actOk     (actOk),
    .forceExit (forceExit),
    .exitDone  (exitDone)
  );

  assign {csN, rasN, casN, weN} = cmdPins;

endmodule

// File: tb/sdram_pwr_mgr_tb_top.sv
`timescale 1ns/1ps
module sdram_pwr_mgr_tb_top;

  localparam int NB        = 4;
  localparam int TRP       = 3;
  localparam int TCKS      = 2;
  localparam int PD_LIMIT  = 40;
  localparam int PD_MARGIN = 8;
  localparam int FORCE_AT  = PD_LIMIT - PD_MARGIN;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] ACT = 4'b0011;

  logic clk = 1'b0;
  logic rstN;
  logic preReq, preAll, actReq, actA10, accReq, accBusy, pdReq, wakeReq;
  logic [1:0] preBank, actBank, accBank;
  logic csN, rasN, casN, weN, a10, cke, pdActive, pdMode, accGrant, accReject;
  logic [1:0] ba;
  logic [NB-1:0] bankOpen;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] expOpen;

  always #5 clk = ~clk;

  sdram_pwr_mgr #(
    .NUM_BANKS (NB), .TRP (TRP), .TCKS (TCKS),
    .PD_LIMIT (PD_LIMIT), .PD_MARGIN (PD_MARGIN)
  ) dut_i (
    .clk (clk), .rstN (rstN),
    .preReq (preReq), .preAll (preAll), .preBank (preBank),
    .actReq (actReq), .actBank (actBank), .actA10 (actA10),
    .accReq (accReq), .accBank (accBank), .accBusy (accBusy),
    .pdReq (pdReq), .wakeReq (wakeReq),
    .csN (csN), .rasN (rasN), .casN (casN), .weN (weN),
    .a10 (a10), .ba (ba), .cke (cke), .bankOpen (bankOpen),
    .pdActive (pdActive), .pdMode (pdMode),
    .accGrant (accGrant), .accReject (accReject)
  );

  function automatic logic [3:0] pins();
    return {csN, rasN, casN, weN};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic issueAct(input logic [1:0] b, input logic a);
    actReq = 1'b1; actBank = b; actA10 = a;
    cyc();
    actReq = 1'b0;
    expOpen[b] = 1'b1;
    chk("R3 act pins", int'(pins()), int'(ACT));
    chk("R3 act ba", int'(ba), int'(b));
    chk("R3 act a10", int'(a10), int'(a));
    chk("R3 act bankOpen", int'(bankOpen), int'(expOpen));
  endtask

  task automatic issuePre(input logic all, input logic [1:0] b);
    preReq = 1'b1; preAll = all; preBank = b;
    cyc();
    preReq = 1'b0;
    if (all) expOpen = '0;
    else     expOpen[b] = 1'b0;
    chk(all ? "R1 pre pins" : "R2 pre pins", int'(pins()), int'(PRE));
    chk(all ? "R1 pre a10" : "R2 pre a10", int'(a10), int'(all));
    chk(all ? "R1 pre ba" : "R2 pre ba", int'(ba), all ? 0 : int'(b));
    chk(all ? "R1 bankOpen" : "R2 bankOpen", int'(bankOpen), int'(expOpen));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  initial begin
    int n;
    rstN = 1'b0;
    preReq = 0; preAll = 0; preBank = 0; actReq = 0; actBank = 0; actA10 = 0;
    accReq = 0; accBank = 0; accBusy = 0; pdReq = 0; wakeReq = 0;
    expOpen = '0;
    cyc(3);
    rstN = 1'b1;
    cyc();
    // R10 reset state
    chk("R10 pins", int'(pins()), int'(NOP));
    chk("R10 cke", int'(cke), 1);
    chk("R10 bankOpen", int'(bankOpen), 0);
    chk("R10 pdActive", int'(pdActive), 0);
    chk("R10 pdMode", int'(pdMode), 0);
    chk("R10 grant/reject", int'({accGrant, accReject}), 0);

    // R3 open every bank, then R2 close each singly
    for (int b = 0; b < NB; b++) issueAct(2'(b), 1'(b));
    for (int b = 0; b < NB; b++) issuePre(1'b0, 2'(b));
    cyc(TRP);

    // R3 precharge delay measured per bank
    for (int b = 0; b < NB; b++) begin
      issueAct(2'(b), 1'b0);
      issuePre(1'b0, 2'(b));
      actReq = 1'b1; actBank = 2'(b); actA10 = 1'b1;
      n = 0;
      do begin cyc(); n++; end while (pins() != ACT && n < 20);
      actReq = 1'b0;
      expOpen[b] = 1'b1;
      chk("R3 tRP cycles", n, TRP);
      chk("R3 reopen bankOpen", int'(bankOpen), int'(expOpen));
    end
    // R3 open request to an already open bank is not issued
    actReq = 1'b1; actBank = 2'd2;
    cyc(2);
    chk("R3 open bank no act", int'(pins()), int'(NOP));
    actReq = 1'b0;

    // Sweep all open-bank patterns
    for (int m = 0; m < 16; m++) begin
      issuePre(1'b1, 2'd0);
      cyc(TRP);
      for (int b = 0; b < NB; b++) if (m[b]) issueAct(2'(b), 1'b0);
      for (int b = 0; b < NB; b++) begin
        accReq = 1'b1; accBank = 2'(b);
        cyc();
        accReq = 1'b0;
        chk("R4 grant", int'(accGrant), int'(m[b]));
        chk("R4 reject", int'(accReject), int'(!m[b]));
      end
      pdReq = 1'b1;
      cyc();
      pdReq = 1'b0;
      chk("R5 cke low", int'(cke), 0);
      chk("R5 nop", int'(pins()), int'(NOP));
      chk("R5 pdActive", int'(pdActive), 1);
      chk("R6 pdMode", int'(pdMode), int'(m != 0));
      preReq = 1'b1; preAll = 1'b1; actReq = 1'b1; actBank = 2'd0;
      accReq = 1'b1; accBank = 2'd0;
      cyc();
      preReq = 1'b0; actReq = 1'b0; accReq = 1'b0;
      chk("R7 pd pins", int'(pins()), int'(NOP));
      chk("R4 reject in pd", int'(accReject), 1);
      cyc();
      chk("R7 pd bankOpen", int'(bankOpen), m);
      chk("R6 pdMode held", int'(pdMode), int'(m != 0));
      wakeReq = 1'b1;
      cyc();
      wakeReq = 1'b0;
      chk("R8 cke high", int'(cke), 1);
      chk("R8 pdActive low", int'(pdActive), 0);
      preReq = 1'b1; preAll = 1'b1;
      n = 0;
      do begin
        if (pins() != NOP) chk("R8 exit nop", int'(pins()), int'(NOP));
        cyc(); n++;
      end while (pins() != PRE && n < 20);
      preReq = 1'b0;
      expOpen = '0;
      chk("R8 first cmd delay", n, TCKS + 1);
      chk("R1 close after exit", int'(bankOpen), 0);
    end
    cyc(TRP);

    // R5 entry blocked by accBusy
    accBusy = 1'b1; pdReq = 1'b1;
    cyc(4);
    chk("R5 busy blocks", int'(cke), 1);
    accBusy = 1'b0;
    cyc();
    pdReq = 1'b0;
    chk("R5 entry after busy", int'(cke), 0);
    // R9 forced exit count
    n = 0;
    while (cke == 1'b0 && n < 200) begin cyc(); n++; end
    chk("R9 forced exit cycles", n, FORCE_AT);
    cyc(TCKS + 2);

    // R11 close beats open in the same cycle
    preReq = 1'b1; preAll = 1'b0; preBank = 2'd1;
    actReq = 1'b1; actBank = 2'd3;
    cyc();
    preReq = 1'b0; actReq = 1'b0;
    chk("R11 priority", int'(pins()), int'(PRE));
    chk("R11 bank3 stays idle", int'(bankOpen[3]), 0);
    cyc(2);
    finishSim();
  end

endmodule